// File: doc/BRIEF.md
# Oversampled SPI Frame Receiver

This block receives fixed-length frames from an external SPI master that uses mode 0 (clock idles low, data sampled on the rising clock edge). The block runs on a single fast system clock. The serial clock, the active-low select and the data input are never used as clocks. All three are treated as asynchronous data: each passes through a two-stage synchronizer. Edges are then found by comparing the synchronized level with the value held from the previous system cycle.

When the select line falls, the block clears its shift register and bit counter. Each rising serial-clock edge seen while the block is selected shifts one data bit in at the low end, so the first bit received ends up most significant. When the select line rises, the block checks the frame length. A frame of exactly the nominal length publishes a 6-bit LED field and a 4-bit chip-ID field and clears the error flag. A frame of any other length sets the error flag and leaves both fields unchanged.

The system clock must run at least eight times faster than the serial clock, for example 100 MHz against 10 MHz.

Top module: `spi_frame_rx`

## Requirements
- R1: After a synchronous active-high reset, `led_o` is 0, `chip_id_o` is 4'hF (no device selected) and `frame_err_o` is 0.
- R2: After a frame of exactly 32 bits, sent MSB first, the 32-bit word is the bits in the order received. `led_o` takes word bits [5:0] and `chip_id_o` takes word bits [27:24]. Word bits [31:28] never reach `chip_id_o`.
- R3: The outputs change only on the third rising system-clock edge after `csn_i` goes high. This delay is two synchronizer stages plus one output register. At all other times the outputs hold their values.
- R4: A frame shorter than 32 bits sets `frame_err_o` to 1 and leaves `led_o` and `chip_id_o` unchanged.
- R5: A frame longer than 32 bits sets `frame_err_o` to 1 and leaves the fields unchanged. The bit counter saturates at 63, so a 96-bit frame is also flagged and does not wrap around to a count of 32.
- R6: A correct 32-bit frame clears `frame_err_o` to 0 and updates both fields.
- R7: A falling `csn_i` clears the shift register and the bit counter. A correct frame that follows an aborted one therefore commits exactly its own 32 bits.
- R8: Rising `sck_i` edges while `csn_i` is high are ignored. They shift nothing, and the outputs do not change.
- R9: `mosi_i` is taken only at the rising edge of `sck_i`. A change of `mosi_i` while `sck_i` is high has no effect on the received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from master, asynchronous |
| csn_i | input | 1 | Active-low select from master, asynchronous |
| mosi_i | input | 1 | Serial data from master, asynchronous |
| led_o | output | 6 | LED field of the last good frame |
| chip_id_o | output | 4 | Chip-ID field of the last good frame |
| frame_err_o | output | 1 | Set when the last frame had the wrong bit count |

## Verification
Good frames are sent with three different words:
- a mixed pattern;
- a word whose top nibble is zero, against ones in bits [27:24];
- a word whose top nibble is set, against zeros in bits [27:24].

Together these separate a correct field slice from one shifted by a bit or taken from the wrong nibble. In every frame, `mosi_i` is inverted while the serial clock is high, so sampling on the wrong edge gives the complemented word.

Frames of 20, 33 and 96 bits separate a strict length check from a loose one. The 96-bit case also separates a saturating counter from a wrapping one. A burst of serial-clock edges while deselected shows whether the select gating is applied.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
    // synchronized view of the three serial pins
    typedef struct packed {
        logic sck;
        logic csn;
        logic mosi;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sck: 1'b0, csn: 1'b1, mosi: 1'b0};
endpackage

// File: rtl/rx_sync_bank.sv
module rx_sync_bank #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic meta;
        logic sync;
    } stage_t;

    for (genvar i = 0; i < W; i++) begin : g_bit
        stage_t st_d, st_q;

        always_comb begin
            st_d      = st_q;
            st_d.meta = async_i[i];
            st_d.sync = st_q.meta;
        end

        always_ff @(posedge clk) begin
            if (rst) st_q <= '{meta: RST_VAL[i], sync: RST_VAL[i]};
            else     st_q <= st_d;
        end

        assign sync_o[i] = st_q.sync;
    end
endmodule

// File: rtl/rx_frame_core.sv
module rx_frame_core #(
    parameter int FRAME_W = 32,
    parameter int LED_W   = 6,
    parameter int ID_LSB  = 24,
    parameter int ID_W    = 4,
    parameter int CNT_W   = $clog2(FRAME_W) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             active_i,
    input  logic             shift_en_i,
    input  logic             bit_i,
    output logic [LED_W-1:0] led_field_o,
    output logic [ID_W-1:0]  id_field_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (start_i) begin
            c_d.shreg = '0;
            c_d.cnt   = '0;
        end else if (shift_en_i && active_i) begin
            c_d.shreg = {c_q.shreg[FRAME_W-2:0], bit_i};
            if (c_q.cnt != CNT_MAX) c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign led_field_o = c_q.shreg[LED_W-1:0];
    assign id_field_o  = c_q.shreg[ID_LSB+ID_W-1:ID_LSB];
    assign count_o     = c_q.cnt;

    // R7: select fall empties the frame state
    p_clear_on_start_r7: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (c_q.shreg == '0) && (c_q.cnt == '0));

    // R5: counter holds at its ceiling
    p_cnt_saturates_r5: assert property (@(posedge clk) disable iff (rst)
        (c_q.cnt == CNT_MAX) && shift_en_i && active_i && !start_i |=> c_q.cnt == CNT_MAX);

    // R8: clock edges while deselected leave frame state untouched
    p_ignore_deselected_r8: assert property (@(posedge clk) disable iff (rst)
        shift_en_i && !active_i && !start_i |=> $stable(c_q.shreg) && $stable(c_q.cnt));
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
    parameter int FRAME_W = 32,
    parameter int LED_W   = 6,
    parameter int ID_LSB  = 24,
    parameter int ID_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck_i,
    input  logic             csn_i,
    input  logic             mosi_i,
    output logic [LED_W-1:0] led_o,
    output logic [ID_W-1:0]  chip_id_o,
    output logic             frame_err_o
);
    import spi_rx_pkg::*;

    localparam int               PIN_W   = $bits(pins_t);
    localparam int               CNT_W   = $clog2(FRAME_W) + 1;
    localparam logic [CNT_W-1:0] GOOD_CNT = CNT_W'(FRAME_W);

    pins_t            raw, syn;
    logic [PIN_W-1:0] syn_vec;

    assign raw = '{sck: sck_i, csn: csn_i, mosi: mosi_i};

    rx_sync_bank #(.W(PIN_W), .RST_VAL(PINS_IDLE)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw),
        .sync_o  (syn_vec)
    );
    assign syn = pins_t'(syn_vec);

    typedef struct packed {
        logic             sck_prev;
        logic             cs_prev;
        logic [LED_W-1:0] led;
        logic [ID_W-1:0]  id;
        logic             err;
    } top_t;

    top_t t_d, t_q;
    logic sck_rise, cs_fall, cs_rise;
    logic [LED_W-1:0] led_field;
    logic [ID_W-1:0]  id_field;
    logic [CNT_W-1:0] bit_count;

    assign sck_rise = syn.sck & ~t_q.sck_prev;
    assign cs_fall  = ~syn.csn & t_q.cs_prev;
    assign cs_rise  = syn.csn & ~t_q.cs_prev;

    rx_frame_core #(
        .FRAME_W (FRAME_W),
        .LED_W   (LED_W),
        .ID_LSB  (ID_LSB),
        .ID_W    (ID_W),
        .CNT_W   (CNT_W)
    ) u_core (
        .clk         (clk),
        .rst         (rst),
        .start_i     (cs_fall),
        .active_i    (~syn.csn),
        .shift_en_i  (sck_rise),
        .bit_i       (syn.mosi),
        .led_field_o (led_field),
        .id_field_o  (id_field),
        .count_o     (bit_count)
    );

    always_comb begin
        t_d          = t_q;
        t_d.sck_prev = syn.sck;
        t_d.cs_prev  = syn.csn;
        if (cs_rise) begin
            if (bit_count == GOOD_CNT) begin
                t_d.led = led_field;
                t_d.id  = id_field;
                t_d.err = 1'b0;
            end else begin
                t_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '{sck_prev: 1'b0, cs_prev: 1'b1, led: '0, id: '1, err: 1'b0};
        else     t_q <= t_d;
    end

    assign led_o       = t_q.led;
    assign chip_id_o   = t_q.id;
    assign frame_err_o = t_q.err;

    // R3: outputs move only right after a detected select rise
    p_hold_between_commits_r3: assert property (@(posedge clk) disable iff (rst)
        !cs_rise |=> $stable(led_o) && $stable(chip_id_o) && $stable(frame_err_o));

    // R4/R5: wrong length raises the flag and keeps the fields
    p_bad_frame_kept_r4: assert property (@(posedge clk) disable iff (rst)
        cs_rise && (bit_count != GOOD_CNT) |=> frame_err_o && $stable(led_o) && $stable(chip_id_o));

    // R6: exact length clears the flag
    p_good_frame_clears_r6: assert property (@(posedge clk) disable iff (rst)
        cs_rise && (bit_count == GOOD_CNT) |=> !frame_err_o);
endmodule

// File: tb/spi_frame_rx_tb.sv
module spi_frame_rx_tb;
    localparam int CLK_T = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic [5:0] led;
    logic [3:0] cid;
    logic       err;
    int         n_chk = 0, n_bad = 0;
    logic [5:0] exp_led = '0;
    logic [3:0] exp_id  = 4'hF;

    always #(CLK_T/2) clk = ~clk;

    spi_frame_rx u_dut (
        .clk(clk), .rst(rst), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
        .led_o(led), .chip_id_o(cid), .frame_err_o(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one bit; data flips while sck is high (R9)
    task automatic put_bit(input logic b);
        mosi = b;
        wait_n(4);
        sck = 1'b1;
        wait_n(2);
        mosi = ~b;
        wait_n(2);
        sck = 1'b0;
    endtask

    // frame of n bits, MSB first from v[n-1]; ends right after csn rises
    task automatic send(input logic [127:0] v, input int n);
        csn = 1'b0;
        wait_n(4);
        for (int i = n - 1; i >= 0; i--) put_bit(v[i]);
        wait_n(4);
        csn = 1'b1;
    endtask

    task automatic t_reset;
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        chk("R1 led", {26'd0, led}, 32'd0);
        chk("R1 chip_id", {28'd0, cid}, 32'hF);
        chk("R1 err", {31'd0, err}, 32'd0);
    endtask

    task automatic t_latency(input logic [31:0] w);
        send({96'd0, w}, 32);
        wait_n(2);
        chk("R3 led held two clocks", {26'd0, led}, {26'd0, exp_led});
        wait_n(1);
        exp_led = w[5:0];
        exp_id  = w[27:24];
        chk("R3 led on third clock", {26'd0, led}, {26'd0, exp_led});
        chk("R3 chip_id on third clock", {28'd0, cid}, {28'd0, exp_id});
    endtask

    task automatic t_good(input logic [31:0] w, input string tag);
        send({96'd0, w}, 32);
        wait_n(6);
        exp_led = w[5:0];
        exp_id  = w[27:24];
        chk({tag, " led"}, {26'd0, led}, {26'd0, exp_led});
        chk({tag, " chip_id"}, {28'd0, cid}, {28'd0, exp_id});
        chk({tag, " err"}, {31'd0, err}, 32'd0);
    endtask

    task automatic t_bad(input logic [127:0] v, input int n, input string tag);
        send(v, n);
        wait_n(6);
        chk({tag, " err set"}, {31'd0, err}, 32'd1);
        chk({tag, " led kept"}, {26'd0, led}, {26'd0, exp_led});
        chk({tag, " chip_id kept"}, {28'd0, cid}, {28'd0, exp_id});
    endtask

    task automatic t_deselected;
        for (int i = 0; i < 10; i++) put_bit(i[0]);
        wait_n(6);
        chk("R8 led unchanged", {26'd0, led}, {26'd0, exp_led});
        chk("R8 chip_id unchanged", {28'd0, cid}, {28'd0, exp_id});
        chk("R8 err unchanged", {31'd0, err}, 32'd0);
    endtask

    initial begin : watchdog
        wait_n(150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_latency(32'hA5C3_1F2D);
        t_good(32'h0FFF_FFC0, "R2 top nibble clear R9");
        t_good(32'hF000_0015, "R2 top nibble set R9");
        t_bad({108'd0, 20'hABCDE}, 20, "R4 short frame");
        t_good(32'h1234_5678, "R6 R7 recovery");
        t_bad({95'd0, 33'h1_FFFF_FFFF}, 33, "R5 33 bits");
        t_bad({32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h1357_9BDF, 32'h2468_ACE0}, 96, "R5 96 bits no wrap");
        t_good(32'h0300_0021, "R6 clears flag");
        t_deselected();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule